// File: doc/BRIEF.md
# Multi-Context Instruction Sequencer

This block decides, for one processing stream of a dataflow machine, which instruction goes to the stream's processor next. The stream's code is split into several contexts, called colours. Each colour has its own program counter into the stream's instruction slots. Operand arrival marks a slot as primed. A primed slot can issue only while some colour's counter rests on it. That gives sequential order inside a colour and lets the colours run in parallel with one another.

On every cycle all colour counters are examined together, and the lowest-numbered colour whose current slot is primed wins. Low colours therefore suit interrupt-like work. The chosen slot is offered over a valid/ready handshake. When it is accepted, its primed mark is cleared and the owning counter steps forward by one.

Colours are separated by null slots. A null slot never becomes issuable, so a colour that reaches one halts. The block reports a standby state when nothing can issue but some colour is still live, and a done state when every colour rests on a null slot. All counters are loaded at program load time and can be read back at any time for debug.

Top module: `ctx_sequencer`

## Requirements
- R1: After a synchronous reset every counter is 0, no slot is primed, issue_valid is 0, and standby is 1 provided slot 0 is not null.
- R2: With load_en high, the counter of colour load_col takes load_pc at the next clock edge, and any slot index is accepted.
- R3: issue_valid is 1 only when the slot under some colour's counter is primed and is not null, and issue_idx is that slot.
- R4: When several colours are enabled, the lowest-numbered one is offered on issue_col and issue_idx.
- R5: On a cycle with issue_valid and issue_ready both high, the offered colour's counter advances by one, wrapping from the last slot to 0. With issue_ready low, no counter moves.
- R6: A prime_en pulse marks slot prime_idx as primed from the next cycle on. An accepted issue clears its slot's mark, and a prime to the same slot in that cycle wins.
- R7: A colour whose slot is unprimed is passed over without blocking other colours. It is offered again as soon as its slot becomes primed.
- R8: A slot flagged in null_map is never issued, even when it is primed, so a colour that reaches it halts.
- R9: standby is 1 exactly when no colour is enabled and at least one colour is not resting on a null slot.
- R10: done is 1 exactly when every colour's counter rests on a null slot. issue_valid is then 0.
- R11: dbg_pcs carries the counter of colour c in bits [c*PCW +: PCW], where PCW is log2 of the slot count.
- R12: If a load and an accepted issue target the same colour in one cycle, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write a colour counter |
| load_col | input | log2(COLOURS) | Colour whose counter is written |
| load_pc | input | log2(SLOTS) | Value written to the counter |
| prime_en | input | 1 | Operands complete for a slot |
| prime_idx | input | log2(SLOTS) | Slot that became primed |
| null_map | input | SLOTS | One bit per slot, 1 marks a null slot |
| issue_ready | input | 1 | Processor accepts the offered slot |
| issue_valid | output | 1 | A slot is offered |
| issue_idx | output | log2(SLOTS) | Offered slot |
| issue_col | output | log2(COLOURS) | Colour owning the offered slot |
| standby | output | 1 | Nothing enabled, some colour live |
| done | output | 1 | All colours halted |
| dbg_pcs | output | COLOURS*log2(SLOTS) | All colour counters, colour 0 in the low bits |

## Verification
A counter that failed to step, or stepped twice, shows on dbg_pcs at the next sample. It also shows within a few cycles on issue_idx, because the colour then re-offers an old slot or skips one. A primed mark left set after issue makes the same slot appear a second time. A missing mark makes standby rise where an issue was due. Priority errors show as the wrong issue_col on the cycle that two colours are both enabled, so the stimulus arranges such collisions deliberately, along with halts on null slots and a counter wrap.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;

    localparam int unsigned SEQ_COLOURS = 16;
    localparam int unsigned SEQ_SLOTS   = 64;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_HALT = 2'd2
    } seq_mode_e;

    function automatic seq_mode_e classify(input logic any_enabled, input logic all_halted);
        if (all_halted)       return MODE_HALT;
        else if (any_enabled) return MODE_RUN;
        else                  return MODE_IDLE;
    endfunction

endpackage

// File: rtl/ctx_pc_bank.sv
module ctx_pc_bank #(
    parameter int unsigned NCOL = 16,
    parameter int unsigned PCW  = 6,
    localparam int unsigned CW  = $clog2(NCOL)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic [CW-1:0]       load_col,
    input  logic [PCW-1:0]      load_pc,
    input  logic                adv_en,
    input  logic [CW-1:0]       adv_col,
    output logic [NCOL*PCW-1:0] pcs
);
    logic [PCW-1:0] pc_q [NCOL];

    for (genvar c = 0; c < NCOL; c++) begin : g_pc
        always_ff @(posedge clk) begin
            if (rst)
                pc_q[c] <= '0;
            else if (load_en && load_col == CW'(c))
                pc_q[c] <= load_pc;
            else if (adv_en && adv_col == CW'(c))
                pc_q[c] <= pc_q[c] + 1'b1;
        end
        assign pcs[c*PCW +: PCW] = pc_q[c];
    end

    // R5: an accepted issue moves its colour forward by exactly one
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !(load_en && load_col == adv_col)) |=>
        pc_q[$past(adv_col)] == $past(pc_q[adv_col]) + 1'b1);

    // R12: a load beats an advance on the same colour
    a_r12_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> pc_q[$past(load_col)] == $past(load_pc));
endmodule

// File: rtl/ctx_prime_table.sv
module ctx_prime_table #(
    parameter int unsigned SLOTS = 64,
    localparam int unsigned PCW  = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [PCW-1:0]   set_idx,
    input  logic             clr_en,
    input  logic [PCW-1:0]   clr_idx,
    output logic [SLOTS-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (clr_en) flags[clr_idx] <= 1'b0;
            if (set_en) flags[set_idx] <= 1'b1;
        end
    end

    // R6: arrival of operands marks the slot
    a_r6_set: assert property (@(posedge clk) disable iff (rst)
        set_en |=> flags[$past(set_idx)]);

    // R6: an issued slot loses its mark unless re-primed in the same cycle
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !flags[$past(clr_idx)]);
endmodule

// File: rtl/ctx_pick.sv
module ctx_pick #(
    parameter int unsigned NCOL = 16,
    localparam int unsigned CW  = $clog2(NCOL)
) (
    input  logic [NCOL-1:0] cand,
    output logic            found,
    output logic [CW-1:0]   col
);
    always_comb begin
        found = 1'b0;
        col   = '0;
        for (int c = NCOL - 1; c >= 0; c--) begin
            if (cand[c]) begin
                found = 1'b1;
                col   = CW'(c);
            end
        end
    end

    // R4: a winner implies a candidate at that colour
    always_comb begin
        if (found) a_r4_winner_real: assert (cand[col]);
    end
endmodule

// File: rtl/ctx_sequencer.sv
module ctx_sequencer
    import ctx_seq_pkg::*;
#(
    parameter int unsigned NCOL  = SEQ_COLOURS,
    parameter int unsigned SLOTS = SEQ_SLOTS,
    localparam int unsigned CW   = $clog2(NCOL),
    localparam int unsigned PCW  = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic [CW-1:0]       load_col,
    input  logic [PCW-1:0]      load_pc,
    input  logic                prime_en,
    input  logic [PCW-1:0]      prime_idx,
    input  logic [SLOTS-1:0]    null_map,
    input  logic                issue_ready,
    output logic                issue_valid,
    output logic [PCW-1:0]      issue_idx,
    output logic [CW-1:0]       issue_col,
    output logic                standby,
    output logic                done,
    output logic [NCOL*PCW-1:0] dbg_pcs
);
    logic [NCOL*PCW-1:0] pcs;
    logic [SLOTS-1:0]    flags;
    logic [NCOL-1:0]     cand;
    logic [NCOL-1:0]     halted;
    logic                found;
    logic [CW-1:0]       win_col;
    logic                fire;
    seq_mode_e           mode;

    ctx_pc_bank #(.NCOL(NCOL), .PCW(PCW)) u_pcs (
        .clk(clk), .rst(rst),
        .load_en(load_en), .load_col(load_col), .load_pc(load_pc),
        .adv_en(fire), .adv_col(win_col),
        .pcs(pcs)
    );

    ctx_prime_table #(.SLOTS(SLOTS)) u_flags (
        .clk(clk), .rst(rst),
        .set_en(prime_en), .set_idx(prime_idx),
        .clr_en(fire), .clr_idx(issue_idx),
        .flags(flags)
    );

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [PCW-1:0] cur;
        assign cur       = pcs[c*PCW +: PCW];
        assign halted[c] = null_map[cur];
        assign cand[c]   = flags[cur] & ~null_map[cur];
    end

    ctx_pick #(.NCOL(NCOL)) u_pick (
        .cand(cand), .found(found), .col(win_col)
    );

    assign mode        = classify(found, &halted);
    assign issue_valid = (mode == MODE_RUN);
    assign issue_col   = win_col;
    assign issue_idx   = pcs[win_col*PCW +: PCW];
    assign fire        = issue_valid & issue_ready;
    assign standby     = (mode == MODE_IDLE);
    assign done        = (mode == MODE_HALT);
    assign dbg_pcs     = pcs;

    // R3: only primed slots are offered
    a_r3_primed: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> flags[issue_idx]);

    // R8: null slots never leave
    a_r8_no_null: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> !null_map[issue_idx]);

    // R9, R10: standby, done and issue are mutually exclusive
    a_r9_modes: assert property (@(posedge clk) disable iff (rst)
        $countones({standby, done, issue_valid}) == 1);

    // R5: a stalled offer leaves every counter untouched
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !issue_ready && !load_en) |=> $stable(dbg_pcs));
endmodule

// File: tb/tb_ctx_sequencer.sv
module tb_ctx_sequencer;
    localparam int NCOL = 16;
    localparam int SLOTS = 64;
    localparam int CW = 4;
    localparam int PCW = 6;

    typedef struct packed {
        logic           pv;
        logic [PCW-1:0] pidx;
        logic           rdy;
        logic           ev;
        logic [PCW-1:0] eidx;
        logic [CW-1:0]  ecol;
        logic           estby;
        logic           edone;
    } vec_t;

    // colour0: 10,11,null12  colour1: 20,21,null22  colour2: 30,31,null32  others: null63
    localparam vec_t VECS [11] = '{
        '{1'b1, 6'd20, 1'b1, 1'b0, 6'd0,  4'd0, 1'b1, 1'b0},
        '{1'b1, 6'd10, 1'b1, 1'b1, 6'd20, 4'd1, 1'b0, 1'b0},
        '{1'b1, 6'd30, 1'b1, 1'b1, 6'd10, 4'd0, 1'b0, 1'b0},
        '{1'b1, 6'd21, 1'b0, 1'b1, 6'd30, 4'd2, 1'b0, 1'b0},
        '{1'b1, 6'd11, 1'b0, 1'b1, 6'd21, 4'd1, 1'b0, 1'b0},
        '{1'b0, 6'd0,  1'b1, 1'b1, 6'd11, 4'd0, 1'b0, 1'b0},
        '{1'b0, 6'd0,  1'b1, 1'b1, 6'd21, 4'd1, 1'b0, 1'b0},
        '{1'b1, 6'd12, 1'b1, 1'b1, 6'd30, 4'd2, 1'b0, 1'b0},
        '{1'b1, 6'd31, 1'b1, 1'b0, 6'd0,  4'd0, 1'b1, 1'b0},
        '{1'b0, 6'd0,  1'b1, 1'b1, 6'd31, 4'd2, 1'b0, 1'b0},
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd0,  4'd0, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_en = 1'b0;
    logic [CW-1:0] load_col = '0;
    logic [PCW-1:0] load_pc = '0;
    logic prime_en = 1'b0;
    logic [PCW-1:0] prime_idx = '0;
    logic [SLOTS-1:0] null_map = '0;
    logic issue_ready = 1'b0;
    logic issue_valid;
    logic [PCW-1:0] issue_idx;
    logic [CW-1:0] issue_col;
    logic standby, done;
    logic [NCOL*PCW-1:0] dbg_pcs;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ctx_sequencer dut (
        .clk(clk), .rst(rst),
        .load_en(load_en), .load_col(load_col), .load_pc(load_pc),
        .prime_en(prime_en), .prime_idx(prime_idx), .null_map(null_map),
        .issue_ready(issue_ready), .issue_valid(issue_valid),
        .issue_idx(issue_idx), .issue_col(issue_col),
        .standby(standby), .done(done), .dbg_pcs(dbg_pcs)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pc_of(input int c);
        return int'(dbg_pcs[c*PCW +: PCW]);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        null_map[12] = 1'b1;
        null_map[22] = 1'b1;
        null_map[32] = 1'b1;
        null_map[63] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 valid", int'(issue_valid), 0);
        check("R1 standby", int'(standby), 1);
        check("R1 done", int'(done), 0);
        check("R1 pcs zero", int'(dbg_pcs == '0), 1);

        // R2: load all counters
        for (int c = 0; c < NCOL; c++) begin
            @(negedge clk);
            load_en = 1'b1;
            load_col = CW'(c);
            load_pc = (c == 0) ? 6'd10 : (c == 1) ? 6'd20 : (c == 2) ? 6'd30 : 6'd63;
        end
        @(negedge clk);
        load_en = 1'b0;
        #1;
        check("R2 col0", pc_of(0), 10);
        check("R11 col2 field", pc_of(2), 30);
        check("R11 col15 field", pc_of(15), 63);

        // table walk: R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            prime_en = VECS[i].pv;
            prime_idx = VECS[i].pidx;
            issue_ready = VECS[i].rdy;
            #1;
            check($sformatf("R3 valid step%0d", i), int'(issue_valid), int'(VECS[i].ev));
            if (VECS[i].ev) begin
                check($sformatf("R4 R7 idx step%0d", i), int'(issue_idx), int'(VECS[i].eidx));
                check($sformatf("R4 col step%0d", i), int'(issue_col), int'(VECS[i].ecol));
            end
            check($sformatf("R9 standby step%0d", i), int'(standby), int'(VECS[i].estby));
            check($sformatf("R10 done step%0d", i), int'(done), int'(VECS[i].edone));
        end
        @(negedge clk);
        prime_en = 1'b0;
        issue_ready = 1'b0;
        #1;
        check("R8 halted col0 pc", pc_of(0), 12);
        check("R5 col2 final pc", pc_of(2), 32);

        // R5 wrap: slot 63 live, colour 0 at 63
        null_map[63] = 1'b0;
        load_en = 1'b1;
        load_col = 4'd0;
        load_pc = 6'd63;
        @(negedge clk);
        load_en = 1'b0;
        prime_en = 1'b1;
        prime_idx = 6'd63;
        @(negedge clk);
        prime_en = 1'b0;
        issue_ready = 1'b0;
        #1;
        check("R4 wrap offer col", int'(issue_col), 0);
        check("R5 stall keeps pc", pc_of(0), 63);
        @(negedge clk);
        #1;
        check("R5 stall still 63", pc_of(0), 63);
        issue_ready = 1'b1;
        @(negedge clk);
        issue_ready = 1'b0;
        #1;
        check("R5 wrap to 0", pc_of(0), 0);
        check("R6 cleared after issue", int'(issue_valid), 0);

        // R12: load beats advance on the same colour
        load_en = 1'b1;
        load_col = 4'd1;
        load_pc = 6'd40;
        @(negedge clk);
        load_en = 1'b0;
        prime_en = 1'b1;
        prime_idx = 6'd40;
        @(negedge clk);
        prime_en = 1'b0;
        #1;
        check("R3 offer idx40", int'(issue_idx), 40);
        issue_ready = 1'b1;
        load_en = 1'b1;
        load_col = 4'd1;
        load_pc = 6'd50;
        @(negedge clk);
        load_en = 1'b0;
        issue_ready = 1'b0;
        #1;
        check("R12 load wins", pc_of(1), 50);
        check("R6 slot40 consumed", int'(issue_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule